// File: doc/BRIEF.md
# Flash Bank Command Front End

This block sits between a host bus and one NOR-style flash bank. It turns single bus write cycles into commands, holds an 8-bit status word, and tells the read path whether bank reads should return array data, the status word, the signature data or the query data. A block erase takes two writes: a setup code and then a confirm code. The second write carries the block index. The block checks the confirm code and the block's protect flag before it starts the erase. The erase itself runs in an external timer. The timer receives a one-cycle start strobe with the block index and reports completion on a done pulse.

Error bits in the status word are sticky. Only a dedicated clear command or the external reset pin returns them to zero. While an erase is running or suspended, the block accepts only a short list of commands and ignores the rest. Driving the reset pin low abandons any sequence in progress and returns the bank to array reads.

Top module: `fcmd_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `rd_sel` is 0 (array), `status` is 0x80 and `erase_start` is low.
- R2: A single write of 0x50 while idle clears status bits 5, 4, 3 and 1, and leaves `rd_sel` unchanged.
- R3: Error bits (status bits 5, 4, 3 and 1) are never cleared by any write other than an accepted 0x50. The reset pin also clears them.
- R4: A write of 0x20 followed by a write of 0xD0 to an unprotected block raises `erase_start` for exactly one cycle, in the cycle after the confirm write. `erase_blk` shows the confirm write's block index, and status bit 7 is low until the erase ends.
- R5: If the write after 0x20 carries any code other than 0xD0, status bits 5 and 4 are set, no erase starts, and the block returns to idle.
- R6: A 0xD0 confirm to a block whose `blk_prot` bit is set sets status bits 5 and 1 and starts no erase.
- R7: The 0x20 setup write switches `rd_sel` to 1 (status), and the bank stays there through the second write and the erase.
- R8: The read-mode codes set `rd_sel` as follows: 0xFF gives 0 (array), 0x70 gives 1 (status), 0x90 gives 2 (signature) and 0x98 gives 3 (query).
- R9: While an erase runs, only the four read-mode codes and 0xB0 (suspend) are acted on. Every other write, including 0x50 and 0x20, has no effect.
- R10: A 0xB0 write during an erase sets status bits 7 and 6. `erase_done` is ignored while suspended. A 0xD0 write then resumes the erase and clears bits 7 and 6.
- R11: `erase_done` during a running erase sets status bit 7 and returns the block to idle. It outweighs a suspend write in the same cycle, and it has no effect in any other state.
- R12: While `rst_pin_n` is low, the block returns to idle with `rd_sel` 0 and `status` 0x80. Any erase in progress is dropped, and writes are ignored. This holds even when `erase_done` arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Bank reset pin, active low, already synchronous to clk |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_blk | input | BLK_W | Block-select bits of the write address |
| wr_data | input | DATA_W | Write data carrying the command code |
| blk_prot | input | 2**BLK_W | Protect flag per block |
| erase_done | input | 1 | Completion pulse from the erase timer |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| status | output | 8 | Status word |
| erase_start | output | 1 | One-cycle erase launch strobe |
| erase_blk | output | BLK_W | Block index latched at launch |

## Verification
Two pairs of events can arrive in the same clock. The first is the timer's done pulse and a host write, either a suspend or a read-mode change. The second is that done pulse and the reset pin going low. The bench drives `erase_done` in the same cycle as a 0xB0 or 0xFF write, and also in the same cycle as `rst_pin_n` falling. It then expects the following. Completion wins over suspend, so status bit 6 stays low and bit 7 rises. The read-mode part of the write still applies. The reset pin overrides everything and yields 0x80 with array reads.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_CLR_STAT    = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RD_SIG      = 8'h90;
  localparam logic [7:0] CMD_RD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  localparam int SR_W      = 8;
  localparam int SR_READY  = 7;
  localparam int SR_ESUSP  = 6;
  localparam int SR_ERASE  = 5;
  localparam int SR_PROG   = 4;
  localparam int SR_SUPPLY = 3;
  localparam int SR_PROT   = 1;
  localparam logic [SR_W-1:0] SR_ERR_MASK = (SR_W'(1) << SR_ERASE) | (SR_W'(1) << SR_PROG)
                                          | (SR_W'(1) << SR_SUPPLY) | (SR_W'(1) << SR_PROT);
  localparam logic [SR_W-1:0] SR_IDLE_VAL = SR_W'(1) << SR_READY;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIG    = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ERASE,
    ST_SUSP
  } seq_state_e;

  typedef enum logic [3:0] {
    CK_NONE,
    CK_RD_ARRAY,
    CK_RD_STATUS,
    CK_RD_SIG,
    CK_RD_QUERY,
    CK_CLR_STAT,
    CK_ERASE_SETUP,
    CK_CONFIRM,
    CK_SUSPEND,
    CK_OTHER
  } cmd_kind_e;

  typedef struct packed {
    logic reset_all;
    logic clr_err;
    logic set_ready;
    logic clr_ready;
    logic set_susp;
    logic clr_susp;
    logic set_erase;
    logic set_prog;
    logic set_prot;
  } stat_evt_t;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_kind_e         kind,
  output logic              is_rd_mode,
  output rd_mode_e          rd_mode_req
);
  logic [7:0] code;
  assign code = wr_data[7:0];

  always_comb begin
    kind = CK_NONE;
    if (wr_en) begin
      case (code)
        CMD_RD_ARRAY:    kind = CK_RD_ARRAY;
        CMD_RD_STATUS:   kind = CK_RD_STATUS;
        CMD_RD_SIG:      kind = CK_RD_SIG;
        CMD_RD_QUERY:    kind = CK_RD_QUERY;
        CMD_CLR_STAT:    kind = CK_CLR_STAT;
        CMD_ERASE_SETUP: kind = CK_ERASE_SETUP;
        CMD_CONFIRM:     kind = CK_CONFIRM;
        CMD_SUSPEND:     kind = CK_SUSPEND;
        default:         kind = CK_OTHER;
      endcase
    end
  end

  always_comb begin
    is_rd_mode  = 1'b1;
    rd_mode_req = RM_ARRAY;
    case (kind)
      CK_RD_ARRAY:  rd_mode_req = RM_ARRAY;
      CK_RD_STATUS: rd_mode_req = RM_STATUS;
      CK_RD_SIG:    rd_mode_req = RM_SIG;
      CK_RD_QUERY:  rd_mode_req = RM_QUERY;
      default:      is_rd_mode  = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_ok,
  input  cmd_kind_e        kind,
  input  logic             is_rd_mode,
  input  rd_mode_e         rd_mode_req,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             prot_hit,
  input  logic             erase_done,
  output rd_mode_e         rd_mode,
  output logic             erase_start,
  output logic [BLK_W-1:0] erase_blk,
  output stat_evt_t        evt
);
  seq_state_e state, state_nxt;
  rd_mode_e   mode_nxt;
  logic       start_nxt;

  always_comb begin
    state_nxt = state;
    mode_nxt  = rd_mode;
    start_nxt = 1'b0;
    evt       = '0;
    if (!pin_ok) begin
      state_nxt     = ST_IDLE;
      mode_nxt      = RM_ARRAY;
      evt.reset_all = 1'b1;
    end else begin
      if (state != ST_SETUP && is_rd_mode) begin
        mode_nxt = rd_mode_req;
      end
      case (state)
        ST_IDLE: begin
          if (kind == CK_CLR_STAT) begin
            evt.clr_err = 1'b1;
          end else if (kind == CK_ERASE_SETUP) begin
            state_nxt = ST_SETUP;
            mode_nxt  = RM_STATUS;
          end
        end
        ST_SETUP: begin
          if (kind != CK_NONE) begin
            state_nxt = ST_IDLE;
            mode_nxt  = RM_STATUS;
            if (kind != CK_CONFIRM) begin
              evt.set_erase = 1'b1;
              evt.set_prog  = 1'b1;
            end else if (prot_hit) begin
              evt.set_erase = 1'b1;
              evt.set_prot  = 1'b1;
            end else begin
              state_nxt     = ST_ERASE;
              start_nxt     = 1'b1;
              evt.clr_ready = 1'b1;
            end
          end
        end
        ST_ERASE: begin
          if (erase_done) begin
            state_nxt     = ST_IDLE;
            evt.set_ready = 1'b1;
          end else if (kind == CK_SUSPEND) begin
            state_nxt     = ST_SUSP;
            evt.set_ready = 1'b1;
            evt.set_susp  = 1'b1;
          end
        end
        default: begin
          if (kind == CK_CONFIRM) begin
            state_nxt     = ST_ERASE;
            evt.clr_ready = 1'b1;
            evt.clr_susp  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rd_mode     <= RM_ARRAY;
      erase_start <= 1'b0;
      erase_blk   <= '0;
    end else begin
      state       <= state_nxt;
      rd_mode     <= mode_nxt;
      erase_start <= start_nxt;
      if (start_nxt) begin
        erase_blk <= blk_idx;
      end
    end
  end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  stat_evt_t       evt,
  output logic [SR_W-1:0] sr
);
  logic [SR_W-1:0] sr_nxt;

  always_comb begin
    sr_nxt = sr;
    if (evt.clr_err)   sr_nxt = sr_nxt & ~SR_ERR_MASK;
    if (evt.set_erase) sr_nxt[SR_ERASE] = 1'b1;
    if (evt.set_prog)  sr_nxt[SR_PROG]  = 1'b1;
    if (evt.set_prot)  sr_nxt[SR_PROT]  = 1'b1;
    if (evt.set_ready) sr_nxt[SR_READY] = 1'b1;
    if (evt.clr_ready) sr_nxt[SR_READY] = 1'b0;
    if (evt.set_susp)  sr_nxt[SR_ESUSP] = 1'b1;
    if (evt.clr_susp)  sr_nxt[SR_ESUSP] = 1'b0;
    if (evt.reset_all) sr_nxt = SR_IDLE_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= SR_IDLE_VAL;
    else     sr <= sr_nxt;
  end
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl #(
  parameter int BLK_W  = 3,
  parameter int DATA_W = 8,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_pin_n,
  input  logic               wr_en,
  input  logic [BLK_W-1:0]   wr_blk,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_BLK-1:0] blk_prot,
  input  logic               erase_done,
  output logic [1:0]         rd_sel,
  output logic [7:0]         status,
  output logic               erase_start,
  output logic [BLK_W-1:0]   erase_blk
);
  import fcmd_pkg::*;

  cmd_kind_e kind;
  logic      is_rd_mode;
  rd_mode_e  rd_mode_req;
  rd_mode_e  rd_mode;
  stat_evt_t evt;
  logic      prot_hit;

  assign prot_hit = blk_prot[wr_blk];

  fcmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .kind        (kind),
    .is_rd_mode  (is_rd_mode),
    .rd_mode_req (rd_mode_req)
  );

  fcmd_seq #(.BLK_W(BLK_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .pin_ok      (rst_pin_n),
    .kind        (kind),
    .is_rd_mode  (is_rd_mode),
    .rd_mode_req (rd_mode_req),
    .blk_idx     (wr_blk),
    .prot_hit    (prot_hit),
    .erase_done  (erase_done),
    .rd_mode     (rd_mode),
    .erase_start (erase_start),
    .erase_blk   (erase_blk),
    .evt         (evt)
  );

  fcmd_status u_stat (
    .clk (clk),
    .rst (rst),
    .evt (evt),
    .sr  (status)
  );

  assign rd_sel = rd_mode;
endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_pin_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              erase_done,
  input logic [1:0]        rd_sel,
  input logic [7:0]        status,
  input logic              erase_start
);
  localparam logic [7:0] ERR_BITS = 8'h3A;

  logic wr_clear, wr_confirm;
  assign wr_clear   = wr_en && (wr_data[7:0] == 8'h50);
  assign wr_confirm = wr_en && (wr_data[7:0] == 8'hD0);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> !status[7]);

  p_start_after_confirm_r4: assert property (@(posedge clk) disable iff (rst)
    erase_start |-> $past(wr_confirm && rst_pin_n));

  p_clear_keeps_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_clear && rst_pin_n) |=> $stable(rd_sel));

  p_sticky_err_r3: assert property (@(posedge clk) disable iff (rst)
    (rst_pin_n && !wr_clear) |=>
      ((status & ERR_BITS & $past(status)) == ($past(status) & ERR_BITS)));

  p_done_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (erase_done && rst_pin_n && !status[7]) |=> status[7]);

  p_pin_reset_r12: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_n |=> (rd_sel == 2'd0 && status == 8'h80 && !erase_start));
endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_pin_n   (rst_pin_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .erase_done  (erase_done),
  .rd_sel      (rd_sel),
  .status      (status),
  .erase_start (erase_start)
);

// File: tb/fcmd_ctrl_tb_top.sv
module fcmd_ctrl_tb_top;
  localparam int BLK_W = 3;
  localparam int NB    = 1 << BLK_W;

  logic clk = 1'b0, rst = 1'b1, rst_pin_n = 1'b1, wr_en = 1'b0, erase_done = 1'b0;
  logic [BLK_W-1:0] wr_blk = '0;
  logic [7:0] wr_data = '0;
  logic [NB-1:0] blk_prot = '0;
  logic [1:0] rd_sel;
  logic [7:0] status;
  logic erase_start;
  logic [BLK_W-1:0] erase_blk;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_state = 0;      // 0 idle, 1 after setup, 2 erasing, 3 suspended
  int m_mode = 0;
  int m_blk = 0;
  logic [7:0] m_stat = 8'h80;
  bit m_start = 0;
  logic [7:0] m_c;

  fcmd_ctrl #(.BLK_W(BLK_W), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .wr_en(wr_en), .wr_blk(wr_blk),
    .wr_data(wr_data), .blk_prot(blk_prot), .erase_done(erase_done),
    .rd_sel(rd_sel), .status(status), .erase_start(erase_start), .erase_blk(erase_blk)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    m_start = 0;
    m_c = wr_data;
    if (rst) begin
      m_state = 0; m_mode = 0; m_stat = 8'h80; m_blk = 0;
    end else if (!rst_pin_n) begin
      m_state = 0; m_mode = 0; m_stat = 8'h80;
    end else if (m_state == 1) begin
      if (wr_en) begin
        m_mode = 1;
        m_state = 0;
        if (m_c != 8'hD0) m_stat = m_stat | 8'h30;
        else if (blk_prot[wr_blk]) m_stat = m_stat | 8'h22;
        else begin
          m_state = 2; m_start = 1; m_blk = int'(wr_blk); m_stat[7] = 1'b0;
        end
      end
    end else begin
      if (wr_en) begin
        if (m_c == 8'hFF) m_mode = 0;
        if (m_c == 8'h70) m_mode = 1;
        if (m_c == 8'h90) m_mode = 2;
        if (m_c == 8'h98) m_mode = 3;
      end
      if (m_state == 0) begin
        if (wr_en && m_c == 8'h50) m_stat = m_stat & 8'hC5;
        if (wr_en && m_c == 8'h20) begin m_state = 1; m_mode = 1; end
      end else if (m_state == 2) begin
        if (erase_done) begin m_state = 0; m_stat[7] = 1'b1; end
        else if (wr_en && m_c == 8'hB0) begin m_state = 3; m_stat[7:6] = 2'b11; end
      end else if (m_state == 3) begin
        if (wr_en && m_c == 8'hD0) begin m_state = 2; m_stat[7:6] = 2'b00; end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if ({rd_sel, status, erase_start, erase_blk} !==
          {m_mode[1:0], m_stat, m_start, m_blk[BLK_W-1:0]}) begin
        n_fail++;
        $display("FAIL model %s act=%h/%h/%b/%0d exp=%h/%h/%b/%0d", cur_req,
                 rd_sel, status, erase_start, erase_blk,
                 m_mode[1:0], m_stat, m_start, m_blk);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int blk, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_blk = BLK_W'(blk); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  task automatic start_erase(input int blk);
    wr(blk, 8'h20);
    wr(blk, 8'hD0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    // R1 reset state
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 status", status, 8'h80);
    chk("R1 start", erase_start, 0);

    cur_req = "R8";
    wr(0, 8'h70); chk("R8 status mode", rd_sel, 1);
    wr(0, 8'h90); chk("R8 signature mode", rd_sel, 2);
    wr(0, 8'h98); chk("R8 query mode", rd_sel, 3);
    wr(0, 8'hFF); chk("R8 array mode", rd_sel, 0);

    cur_req = "R5";
    wr(2, 8'h20); chk("R7 setup enters status", rd_sel, 1);
    wr(2, 8'h55); chk("R5 bad confirm", status, 8'hB0);
    chk("R5 no start", erase_start, 0);

    cur_req = "R3";
    wr(0, 8'hFF); wr(0, 8'h70); wr(0, 8'h90);
    chk("R3 errors kept", status, 8'hB0);

    cur_req = "R2";
    wr(0, 8'h50);
    chk("R2 cleared", status, 8'h80);
    chk("R2 mode unchanged", rd_sel, 2);

    cur_req = "R6";
    blk_prot = 8'b0001_0000;
    start_erase(4);
    chk("R6 protect status", status, 8'hA2);
    chk("R6 no start", erase_start, 0);
    chk("R7 status mode", rd_sel, 1);
    wr(0, 8'h50);

    cur_req = "R4";
    wr(1, 8'h20); wr(1, 8'h33);
    start_erase(5);
    chk("R4 start pulse", erase_start, 1);
    chk("R4 block index", erase_blk, 5);
    chk("R4 busy with sticky errors", status, 8'h30);
    @(negedge clk);
    chk("R4 single cycle", erase_start, 0);

    cur_req = "R9";
    wr(0, 8'h50); chk("R9 clear ignored", status, 8'h30);
    wr(0, 8'h20); wr(0, 8'hD0); chk("R9 no second start", erase_start, 0);
    wr(0, 8'hFF); chk("R9 array read allowed", rd_sel, 0);
    wr(0, 8'h70); chk("R9 status read allowed", rd_sel, 1);

    cur_req = "R11";
    done_pulse(); chk("R11 done ready", status, 8'hB0);
    wr(0, 8'h50);
    done_pulse(); chk("R11 done in idle ignored", status, 8'h80);

    cur_req = "R10";
    start_erase(1);
    wr(0, 8'hB0); chk("R10 suspended", status, 8'hC0);
    done_pulse(); chk("R10 done ignored while suspended", status, 8'hC0);
    wr(0, 8'h20); wr(0, 8'h50); chk("R10 others ignored", status, 8'hC0);
    wr(0, 8'hD0); chk("R10 resumed", status, 8'h00);
    done_pulse(); chk("R10 finished", status, 8'h80);

    cur_req = "R11";
    start_erase(3);
    @(negedge clk);
    wr_en = 1'b1; wr_blk = '0; wr_data = 8'hB0; erase_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; erase_done = 1'b0;
    chk("R11 done beats suspend", status, 8'h80);
    start_erase(3);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hFF; erase_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; erase_done = 1'b0;
    chk("R11 done with array read status", status, 8'h80);
    chk("R11 done with array read mode", rd_sel, 0);

    cur_req = "R12";
    start_erase(6);
    @(negedge clk);
    rst_pin_n = 1'b0; wr_en = 1'b1; wr_data = 8'h20;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    rst_pin_n = 1'b1;
    chk("R12 status", status, 8'h80);
    chk("R12 mode", rd_sel, 0);
    done_pulse();
    wr(6, 8'hD0);
    chk("R12 erase dropped", erase_start, 0);
    chk("R12 still idle", status, 8'h80);
    start_erase(0);
    @(negedge clk);
    rst_pin_n = 1'b0; erase_done = 1'b1;
    @(negedge clk);
    rst_pin_n = 1'b1; erase_done = 1'b0;
    chk("R12 pin beats done status", status, 8'h80);
    chk("R12 pin beats done mode", rd_sel, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule